// File: doc/BRIEF.md
# Redundant reference clock selector

This controller watches two reference inputs, a primary (index 0) and a backup (index 1), and decides which one a downstream frequency synthesizer should follow. Each reference is presented as a single-cycle edge strobe in the system clock domain. A local free-running oscillator is presented as a tick strobe and acts as the timebase. Each input is qualified independently. Loss of signal comes from gaps in its strobe stream, and out-of-frequency comes from its strobe count over a fixed gate window of local ticks.

From the qualification flags the controller picks the synthesizer mode. Freerun follows the local oscillator, locked follows the selected input, and holdover replays a frequency word learned earlier. While locked, the block keeps a history of the synthesizer's frequency control word, and that history is what holdover uses. History counts only after several fully locked gate windows have gone by. When the block leaves holdover, the output word slews towards the new input's word in bounded steps instead of jumping. Return from the backup to a recovered primary is optional.

Top module: `refclk_selector`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `mode` is 0 (freerun), `sel_idx` is 0, `los` is 2'b11, `oof` is 2'b00, `hist_valid` is 0, `ramp_active` is 0, and `out_fcw` equals `NOM_FCW`.
- R2: The gate window is 2^GATE_W local ticks, divided into eight subdivisions of 2^(GATE_W-3) ticks, counted from reset. When four consecutive subdivisions of an input pass with no strobe, that input's `los` bit sets on the cycle after the fourth one ends.
- R3: An input's `los` bit clears only at the end of a window, and only when that window and the one before it both had a strobe in every subdivision.
- R4: At each window end, the strobes counted in that window (including one on the final cycle) are compared with `cfg_expected`. If `oof` is clear and the absolute difference is greater than `cfg_oof_set`, `oof` sets.
- R5: A set `oof` bit clears at a window end only when the difference is below `cfg_oof_clr`. A difference between the two thresholds leaves `oof` unchanged.
- R6: An input is valid when neither its `los` nor its `oof` bit is set. `mode` encodes freerun as 0, locked as 1 and holdover as 2. From freerun or holdover, the block enters locked on the primary if the primary is valid, and otherwise on the backup if the backup is valid.
- R7: While locked, if the selected input becomes invalid and the other input is valid, `sel_idx` moves to the other input and the mode stays locked.
- R8: While locked, if the selected input becomes invalid and the other input is not valid, the mode becomes holdover when `hist_valid` is set and freerun when it is not.
- R9: A learning window is a gate window spent wholly in locked mode with no ramp running. `hist_valid` sets once `HIST_WINS` learning windows have completed, and it clears when the mode goes to freerun.
- R10: At the end of each learning window, `hold_fcw` takes the mean of `synth_fcw` sampled on every local tick of that window. It stays unchanged for as long as the mode is holdover.
- R11: While locked on the backup with both inputs valid, the block moves to the primary only when `revert_en` is 1.
- R12: When the mode goes from holdover to locked, `ramp_active` sets and `out_fcw` starts at `hold_fcw`. On each local tick `out_fcw` moves towards `synth_fcw` by `cfg_ramp_step`. Once the remaining distance is no more than one step, `out_fcw` equals `synth_fcw` and `ramp_active` clears.
- R13: Outside a ramp, `out_fcw` is registered from the current mode: `synth_fcw` when locked, `hold_fcw` in holdover, and `NOM_FCW` in freerun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Local oscillator tick strobe |
| in_strobe | input | 2 | Edge strobes of the primary (bit 0) and backup (bit 1) references |
| synth_fcw | input | FW | Synthesizer frequency control word being sampled |
| cfg_expected | input | CNT_W | Expected strobe count per gate window |
| cfg_oof_set | input | CNT_W | Count deviation above which out-of-frequency asserts |
| cfg_oof_clr | input | CNT_W | Count deviation below which out-of-frequency clears |
| cfg_ramp_step | input | FW | Largest change of the output word per local tick during a ramp |
| revert_en | input | 1 | Allow a return to the primary once it is valid again |
| sel_idx | output | 1 | Selected input index |
| mode | output | 2 | Operating mode: 0 freerun, 1 locked, 2 holdover |
| los | output | 2 | Per-input loss-of-signal flags |
| oof | output | 2 | Per-input out-of-frequency flags |
| hist_valid | output | 1 | Enough learned history for holdover |
| hold_fcw | output | FW | Stored holdover frequency word |
| out_fcw | output | FW | Frequency word presented to the synthesizer |
| ramp_active | output | 1 | Output word still slewing after holdover |

## Verification
The bench drives the backup's strobe rate above the assert threshold, then into the band between the two thresholds, then below the clear threshold. A design without hysteresis would bounce back to locked while the rate sat inside the band. It drops both inputs twice: first before history has built up, where a design that ignores history validity would enter holdover with a stale word, and then after history is valid, where holdover must hold its word frozen while the synthesizer word moves. It recovers the primary with the revertive option off and then on, which catches a design that reverts unconditionally. After holdover it checks the ramp, which catches a design that steps straight to the new word or stays stuck in ramping. A behavioural reference model compares every output on every cycle, so the exact cycle at which each flag and mode changes is checked as well.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    typedef enum logic [1:0] {
        MODE_FREE = 2'd0,
        MODE_LOCK = 2'd1,
        MODE_HOLD = 2'd2
    } rcs_mode_e;

    typedef struct packed {
        rcs_mode_e mode;
        logic      sel;
    } rcs_ctl_t;

endpackage

// File: rtl/rcs_gate.sv
module rcs_gate #(
    parameter int GATE_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    output logic win_end,
    output logic sub_end
);
    localparam int SUB_W = GATE_W - 3;

    typedef struct packed {
        logic [GATE_W-1:0] tcnt;
    } gate_st_t;

    gate_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (ref_tick) begin
            st_d.tcnt = st_q.tcnt + 1'b1;
        end
        win_end = ref_tick && (&st_q.tcnt);
        sub_end = ref_tick && (&st_q.tcnt[SUB_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rcs_qual.sv
module rcs_qual #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_end,
    input  logic             sub_end,
    input  logic             strobe,
    input  logic [CNT_W-1:0] cfg_expected,
    input  logic [CNT_W-1:0] cfg_set,
    input  logic [CNT_W-1:0] cfg_clr,
    output logic             los,
    output logic             oof
);
    localparam logic [CNT_W-1:0] CNT_MAX    = '1;
    localparam logic [2:0]       QUIET_LIM  = 3'd4;
    localparam logic [1:0]       GOOD_LIM   = 2'd2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             seen;
        logic [2:0]       quiet;
        logic             dirty;
        logic [1:0]       good;
        logic             los;
        logic             oof;
    } qual_st_t;

    qual_st_t         st_q, st_d;
    logic [CNT_W-1:0] meas;
    logic [CNT_W-1:0] delta;
    logic             silent;
    logic             win_good;

    always_comb begin
        st_d   = st_q;
        meas   = (st_q.cnt == CNT_MAX) ? CNT_MAX : st_q.cnt + {{(CNT_W-1){1'b0}}, strobe};
        delta  = (meas >= cfg_expected) ? (meas - cfg_expected) : (cfg_expected - meas);
        silent = sub_end && !(st_q.seen || strobe);
        win_good = win_end && !(st_q.dirty || silent);

        st_d.cnt   = win_end ? '0 : meas;
        st_d.seen  = sub_end ? 1'b0 : (st_q.seen || strobe);
        st_d.dirty = win_end ? 1'b0 : (st_q.dirty || silent);

        if (sub_end) begin
            if (silent) begin
                st_d.quiet = (st_q.quiet == QUIET_LIM) ? QUIET_LIM : st_q.quiet + 3'd1;
            end else begin
                st_d.quiet = 3'd0;
            end
        end

        if (win_end) begin
            st_d.good = win_good ? ((st_q.good == GOOD_LIM) ? GOOD_LIM : st_q.good + 2'd1) : 2'd0;
        end

        if (silent && (st_q.quiet >= 3'd3)) begin
            st_d.los = 1'b1;
        end else if (st_q.los && win_good && (st_q.good != 2'd0)) begin
            st_d.los = 1'b0;
        end

        if (win_end) begin
            if (st_q.oof) begin
                if (delta < cfg_clr) begin
                    st_d.oof = 1'b0;
                end
            end else if (delta > cfg_set) begin
                st_d.oof = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.los <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign los = st_q.los;
    assign oof = st_q.oof;

    AST_LOS_SETS_AT_SUB: assert property (@(posedge clk) disable iff (!rst_n) $rose(st_q.los) |-> $past(sub_end)); // R2
    AST_LOS_CLEARS_AT_WIN: assert property (@(posedge clk) disable iff (!rst_n) $fell(st_q.los) |-> $past(win_end)); // R3
    AST_OOF_SET_ABOVE: assert property (@(posedge clk) disable iff (!rst_n) $rose(st_q.oof) |-> ($past(win_end) && ($past(delta) > $past(cfg_set)))); // R4
    AST_OOF_CLEAR_BELOW: assert property (@(posedge clk) disable iff (!rst_n) $fell(st_q.oof) |-> ($past(win_end) && ($past(delta) < $past(cfg_clr)))); // R5

endmodule

// File: rtl/rcs_hist.sv
module rcs_hist #(
    parameter int          FW        = 24,
    parameter int          GATE_W    = 16,
    parameter int          HIST_WINS = 8,
    parameter logic [FW-1:0] NOM_FCW = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_tick,
    input  logic          win_end,
    input  logic          learn,
    input  logic          clear,
    input  logic [FW-1:0] fcw,
    output logic [FW-1:0] hold_fcw,
    output logic          hist_valid
);
    localparam int ACC_W = FW + GATE_W;
    localparam int HW_W  = $clog2(HIST_WINS + 1);
    localparam logic [HW_W-1:0] WINS_LIM = HW_W'(HIST_WINS);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [HW_W-1:0]  wins;
        logic [FW-1:0]    hold;
        logic             clean;
    } hist_st_t;

    hist_st_t         st_q, st_d;
    logic [ACC_W-1:0] sum;
    logic             take;

    always_comb begin
        st_d = st_q;
        sum  = st_q.acc + {{GATE_W{1'b0}}, fcw};
        take = win_end && st_q.clean && learn;

        if (win_end) begin
            st_d.acc = '0;
        end else if (ref_tick) begin
            st_d.acc = sum;
        end

        st_d.clean = win_end ? 1'b1 : (st_q.clean && learn);

        if (take) begin
            st_d.hold = sum[ACC_W-1:GATE_W];
            if (st_q.wins != WINS_LIM) begin
                st_d.wins = st_q.wins + 1'b1;
            end
        end

        if (clear) begin
            st_d.wins = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.hold <= NOM_FCW;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_fcw   = st_q.hold;
    assign hist_valid = (st_q.wins == WINS_LIM);

    AST_HOLD_ONLY_ON_LEARN: assert property (@(posedge clk) disable iff (!rst_n) !$stable(st_q.hold) |-> $past(learn && win_end)); // R10
    AST_VALID_AT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(hist_valid) |-> $past(win_end && learn)); // R9

endmodule

// File: rtl/rcs_ramp.sv
module rcs_ramp
    import rcs_pkg::*;
#(
    parameter int            FW      = 24,
    parameter logic [FW-1:0] NOM_FCW = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_tick,
    input  rcs_mode_e     mode,
    input  logic          start,
    input  logic [FW-1:0] hold_fcw,
    input  logic [FW-1:0] target,
    input  logic [FW-1:0] step,
    output logic [FW-1:0] out_fcw,
    output logic          ramp_active
);
    typedef struct packed {
        logic [FW-1:0] out;
        logic          ramp;
    } ramp_st_t;

    ramp_st_t         st_q, st_d;
    logic signed [FW:0] diff;
    logic [FW:0]        mag;

    always_comb begin
        st_d = st_q;
        diff = $signed({1'b0, target}) - $signed({1'b0, st_q.out});
        mag  = diff[FW] ? $unsigned(-diff) : $unsigned(diff);

        if (start) begin
            st_d.out  = hold_fcw;
            st_d.ramp = 1'b1;
        end else if (mode != MODE_LOCK) begin
            st_d.ramp = 1'b0;
            st_d.out  = (mode == MODE_HOLD) ? hold_fcw : NOM_FCW;
        end else if (st_q.ramp) begin
            if (ref_tick) begin
                if (mag <= {1'b0, step}) begin
                    st_d.out  = target;
                    st_d.ramp = 1'b0;
                end else if (diff[FW]) begin
                    st_d.out = st_q.out - step;
                end else begin
                    st_d.out = st_q.out + step;
                end
            end
        end else begin
            st_d.out = target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.out  <= NOM_FCW;
            st_q.ramp <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_fcw     = st_q.out;
    assign ramp_active = st_q.ramp;

    AST_RAMP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ramp && $past(st_q.ramp)) |->
        (((st_q.out >= $past(st_q.out)) ? (st_q.out - $past(st_q.out)) : ($past(st_q.out) - st_q.out)) <= $past(step))); // R12
    AST_RAMP_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.ramp) && ($past(mode) == MODE_LOCK)) |-> (st_q.out == $past(target))); // R12

endmodule

// File: rtl/refclk_selector.sv
module refclk_selector
    import rcs_pkg::*;
#(
    parameter int            GATE_W    = 16,
    parameter int            CNT_W     = GATE_W + 4,
    parameter int            FW        = 24,
    parameter int            HIST_WINS = 8,
    parameter logic [FW-1:0] NOM_FCW   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic [1:0]       in_strobe,
    input  logic [FW-1:0]    synth_fcw,
    input  logic [CNT_W-1:0] cfg_expected,
    input  logic [CNT_W-1:0] cfg_oof_set,
    input  logic [CNT_W-1:0] cfg_oof_clr,
    input  logic [FW-1:0]    cfg_ramp_step,
    input  logic             revert_en,
    output logic             sel_idx,
    output logic [1:0]       mode,
    output logic [1:0]       los,
    output logic [1:0]       oof,
    output logic             hist_valid,
    output logic [FW-1:0]    hold_fcw,
    output logic [FW-1:0]    out_fcw,
    output logic             ramp_active
);
    localparam int NUM_IN = 2;

    logic             win_end;
    logic             sub_end;
    logic [NUM_IN-1:0] los_w;
    logic [NUM_IN-1:0] oof_w;
    logic [NUM_IN-1:0] valid;
    logic             hist_valid_w;
    logic [FW-1:0]    hold_w;
    logic             ramp_w;
    logic             learn;
    logic             hist_clear;
    logic             ramp_start;

    rcs_ctl_t st_q, st_d;

    rcs_gate #(.GATE_W(GATE_W)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .win_end  (win_end),
        .sub_end  (sub_end)
    );

    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_qual
        rcs_qual #(.CNT_W(CNT_W)) u_qual (
            .clk          (clk),
            .rst_n        (rst_n),
            .win_end      (win_end),
            .sub_end      (sub_end),
            .strobe       (in_strobe[gi]),
            .cfg_expected (cfg_expected),
            .cfg_set      (cfg_oof_set),
            .cfg_clr      (cfg_oof_clr),
            .los          (los_w[gi]),
            .oof          (oof_w[gi])
        );
    end

    assign valid = ~los_w & ~oof_w;

    always_comb begin
        st_d = st_q;
        case (st_q.mode)
            MODE_LOCK: begin
                if (!valid[st_q.sel]) begin
                    if (valid[~st_q.sel]) begin
                        st_d.sel = ~st_q.sel;
                    end else if (hist_valid_w) begin
                        st_d.mode = MODE_HOLD;
                    end else begin
                        st_d.mode = MODE_FREE;
                    end
                end else if (st_q.sel && revert_en && valid[0]) begin
                    st_d.sel = 1'b0;
                end
            end
            default: begin
                if (valid[0]) begin
                    st_d.mode = MODE_LOCK;
                    st_d.sel  = 1'b0;
                end else if (valid[1]) begin
                    st_d.mode = MODE_LOCK;
                    st_d.sel  = 1'b1;
                end
            end
        endcase
        learn      = (st_q.mode == MODE_LOCK) && (st_d.mode == MODE_LOCK) && !ramp_w;
        hist_clear = (st_d.mode == MODE_FREE);
        ramp_start = (st_q.mode == MODE_HOLD) && (st_d.mode == MODE_LOCK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MODE_FREE;
            st_q.sel  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    rcs_hist #(
        .FW        (FW),
        .GATE_W    (GATE_W),
        .HIST_WINS (HIST_WINS),
        .NOM_FCW   (NOM_FCW)
    ) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick   (ref_tick),
        .win_end    (win_end),
        .learn      (learn),
        .clear      (hist_clear),
        .fcw        (synth_fcw),
        .hold_fcw   (hold_w),
        .hist_valid (hist_valid_w)
    );

    rcs_ramp #(
        .FW      (FW),
        .NOM_FCW (NOM_FCW)
    ) u_ramp (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_tick    (ref_tick),
        .mode        (st_q.mode),
        .start       (ramp_start),
        .hold_fcw    (hold_w),
        .target      (synth_fcw),
        .step        (cfg_ramp_step),
        .out_fcw     (out_fcw),
        .ramp_active (ramp_w)
    );

    assign sel_idx     = st_q.sel;
    assign mode        = st_q.mode;
    assign los         = los_w;
    assign oof         = oof_w;
    assign hist_valid  = hist_valid_w;
    assign hold_fcw    = hold_w;
    assign ramp_active = ramp_w;

    AST_HOLD_NEEDS_HIST: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == MODE_HOLD) && ($past(st_q.mode) == MODE_LOCK)) |-> $past(hist_valid_w)); // R8
    AST_FREE_WITHOUT_HIST: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == MODE_FREE) && ($past(st_q.mode) == MODE_LOCK)) |-> !$past(hist_valid_w)); // R8
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == MODE_HOLD) && ($past(st_q.mode) == MODE_HOLD)) |-> $stable(hold_w)); // R10
    AST_REVERT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == MODE_LOCK) && ($past(st_q.mode) == MODE_LOCK) && $past(st_q.sel) && !st_q.sel)
        |-> ($past(revert_en) || $past(los_w[1] || oof_w[1]))); // R11

endmodule

// File: tb/tb_refclk_selector.sv
module tb_refclk_selector;
    localparam int GW   = 8;
    localparam int CW   = 12;
    localparam int FWB  = 16;
    localparam int HW   = 3;
    localparam int NOM  = 4096;
    localparam int WIN  = 1 << GW;
    localparam int SUB  = 1 << (GW - 3);
    localparam int CMAX = (1 << CW) - 1;
    localparam int EXPC = 128;
    localparam int OSET = 12;
    localparam int OCLR = 9;
    localparam int STEP = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ref_tick = 1'b0;
    logic [1:0]     in_strobe = 2'b00;
    logic [FWB-1:0] synth_fcw = 16'd5000;
    logic           revert_en = 1'b0;
    logic           sel_idx;
    logic [1:0]     mode;
    logic [1:0]     los;
    logic [1:0]     oof;
    logic           hist_valid;
    logic [FWB-1:0] hold_fcw;
    logic [FWB-1:0] out_fcw;
    logic           ramp_active;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    int inc[2] = '{0, 0};
    int fcw_base = 5000;

    always #4 clk = ~clk;

    refclk_selector #(
        .GATE_W(GW), .CNT_W(CW), .FW(FWB), .HIST_WINS(HW), .NOM_FCW(16'(NOM))
    ) dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .in_strobe(in_strobe),
        .synth_fcw(synth_fcw), .cfg_expected(12'(EXPC)), .cfg_oof_set(12'(OSET)),
        .cfg_oof_clr(12'(OCLR)), .cfg_ramp_step(16'(STEP)), .revert_en(revert_en),
        .sel_idx(sel_idx), .mode(mode), .los(los), .oof(oof), .hist_valid(hist_valid),
        .hold_fcw(hold_fcw), .out_fcw(out_fcw), .ramp_active(ramp_active)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_t;
    int m_cnt[2], m_seen[2], m_quiet[2], m_dirty[2], m_good[2], m_los[2], m_oof[2];
    int m_mode, m_sel, h_acc, h_wins, h_hold, h_clean, r_out, r_ramp;

    task automatic model_reset();
        m_t = 0;
        for (int i = 0; i < 2; i++) begin
            m_cnt[i] = 0; m_seen[i] = 0; m_quiet[i] = 0; m_dirty[i] = 0;
            m_good[i] = 0; m_los[i] = 1; m_oof[i] = 0;
        end
        m_mode = 0; m_sel = 0; h_acc = 0; h_wins = 0; h_hold = NOM; h_clean = 0;
        r_out = NOM; r_ramp = 0;
    endtask

    task automatic model_step();
        int tk, we, se, nmode, nsel, learn, sum, diff, fw;
        int v[2];
        int n_hold, n_wins, n_clean, n_acc, n_out, n_ramp;
        tk = int'(ref_tick);
        fw = int'(synth_fcw);
        we = (tk != 0) && (m_t == WIN - 1);
        se = (tk != 0) && ((m_t % SUB) == SUB - 1);
        for (int i = 0; i < 2; i++) v[i] = (m_los[i] == 0) && (m_oof[i] == 0);
        nmode = m_mode; nsel = m_sel;
        if (m_mode != 1) begin
            if (v[0] != 0) begin nmode = 1; nsel = 0; end
            else if (v[1] != 0) begin nmode = 1; nsel = 1; end
        end else begin
            if (v[m_sel] == 0) begin
                if (v[1 - m_sel] != 0) nsel = 1 - m_sel;
                else if (h_wins == HW) nmode = 2;
                else nmode = 0;
            end else if (m_sel == 1 && revert_en && v[0] != 0) nsel = 0;
        end
        learn = (m_mode == 1) && (nmode == 1) && (r_ramp == 0);
        sum = h_acc + fw;
        n_hold = h_hold; n_wins = h_wins;
        if (we && h_clean != 0 && learn) begin
            n_hold = sum / WIN;
            if (h_wins < HW) n_wins = h_wins + 1;
        end
        if (nmode == 0) n_wins = 0;
        n_clean = we ? 1 : ((h_clean != 0 && learn) ? 1 : 0);
        n_acc = we ? 0 : (tk != 0 ? sum : h_acc);
        n_out = r_out; n_ramp = r_ramp;
        if (m_mode == 2 && nmode == 1) begin
            n_out = h_hold; n_ramp = 1;
        end else if (m_mode != 1) begin
            n_ramp = 0; n_out = (m_mode == 2) ? h_hold : NOM;
        end else if (r_ramp != 0) begin
            if (tk != 0) begin
                diff = fw - r_out;
                if (diff <= STEP && diff >= -STEP) begin n_out = fw; n_ramp = 0; end
                else if (diff < 0) n_out = r_out - STEP;
                else n_out = r_out + STEP;
            end
        end else n_out = fw;
        for (int i = 0; i < 2; i++) begin
            int s, meas, sil, gw, dl;
            s = int'(in_strobe[i]);
            meas = (m_cnt[i] + s > CMAX) ? CMAX : m_cnt[i] + s;
            sil = se && (m_seen[i] == 0) && (s == 0);
            gw = we && (m_dirty[i] == 0) && !sil;
            dl = (meas > EXPC) ? meas - EXPC : EXPC - meas;
            if (sil && m_quiet[i] >= 3) m_los[i] = 1;
            else if (m_los[i] != 0 && gw && m_good[i] >= 1) m_los[i] = 0;
            if (we) begin
                if (m_oof[i] != 0) begin if (dl < OCLR) m_oof[i] = 0; end
                else if (dl > OSET) m_oof[i] = 1;
            end
            if (se) m_quiet[i] = sil ? ((m_quiet[i] >= 4) ? 4 : m_quiet[i] + 1) : 0;
            if (we) m_good[i] = gw ? ((m_good[i] >= 2) ? 2 : m_good[i] + 1) : 0;
            m_cnt[i] = we ? 0 : meas;
            m_seen[i] = se ? 0 : ((m_seen[i] != 0 || s != 0) ? 1 : 0);
            m_dirty[i] = we ? 0 : ((m_dirty[i] != 0 || sil) ? 1 : 0);
        end
        m_mode = nmode; m_sel = nsel;
        h_hold = n_hold; h_wins = n_wins; h_clean = n_clean; h_acc = n_acc;
        r_out = n_out; r_ramp = n_ramp;
        if (tk != 0) m_t = (m_t + 1) % WIN;
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
    end

    // compare every cycle, away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                chk(int'(mode) == m_mode, "R6", "mode", int'(mode), m_mode);
                chk(int'(sel_idx) == m_sel, "R7", "sel_idx", int'(sel_idx), m_sel);
                chk(int'(los[0]) == m_los[0] && int'(los[1]) == m_los[1], "R2", "los",
                    int'(los), m_los[1] * 2 + m_los[0]);
                chk(int'(oof[0]) == m_oof[0] && int'(oof[1]) == m_oof[1], "R4", "oof",
                    int'(oof), m_oof[1] * 2 + m_oof[0]);
                chk(int'(hist_valid) == (h_wins == HW ? 1 : 0), "R9", "hist_valid",
                    int'(hist_valid), (h_wins == HW ? 1 : 0));
                chk(int'(hold_fcw) == h_hold, "R10", "hold_fcw", int'(hold_fcw), h_hold);
                chk(int'(ramp_active) == r_ramp, "R12", "ramp_active", int'(ramp_active), r_ramp);
                chk(int'(out_fcw) == r_out, "R13", "out_fcw", int'(out_fcw), r_out);
            end
        end
    end

    // input driver: local tick every other cycle, strobes from phase accumulators
    initial begin
        int pacc[2] = '{0, 0};
        int par = 0;
        forever begin
            @(negedge clk);
            ref_tick = ~ref_tick;
            if (ref_tick) par = 1 - par;
            synth_fcw = 16'(fcw_base + (par != 0 ? 2 : 0));
            for (int i = 0; i < 2; i++) begin
                pacc[i] += inc[i];
                if (pacc[i] >= 1000) begin
                    pacc[i] -= 1000;
                    in_strobe[i] = 1'b1;
                end else begin
                    in_strobe[i] = 1'b0;
                end
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_mode(input int m, input int lim);
        for (int k = 0; k < lim; k++) begin
            if (int'(mode) == m) break;
            @(negedge clk);
        end
    endtask

    initial begin
        run(5);
        rst_n = 1'b1;
        run(1);
        // R1 reset state
        chk(mode == 2'd0, "R1", "mode after reset", int'(mode), 0);
        chk(sel_idx == 1'b0, "R1", "sel after reset", int'(sel_idx), 0);
        chk(los == 2'b11 && oof == 2'b00, "R1", "los/oof after reset", int'({los, oof}), 12);
        chk(!hist_valid && !ramp_active, "R1", "hist/ramp after reset", int'({hist_valid, ramp_active}), 0);
        chk(out_fcw == 16'(NOM), "R1", "out_fcw after reset", int'(out_fcw), NOM);

        // both inputs on nominal rate: lock on primary (R3, R6)
        inc[0] = 250; inc[1] = 250;
        run(1200);
        chk(los == 2'b00, "R3", "los cleared", int'(los), 0);
        chk(mode == 2'd1 && sel_idx == 1'b0, "R6", "locked on primary", int'({mode, sel_idx}), 2);
        chk(!hist_valid, "R9", "no history yet", int'(hist_valid), 0);

        // lose both without history: freerun (R8)
        inc[0] = 0; inc[1] = 0;
        run(600);
        chk(los == 2'b11, "R2", "both lost", int'(los), 3);
        chk(mode == 2'd0, "R8", "freerun without history", int'(mode), 0);
        chk(out_fcw == 16'(NOM), "R13", "freerun word", int'(out_fcw), NOM);

        // recover and build history (R9, R10)
        inc[0] = 250; inc[1] = 250;
        run(4096);
        chk(mode == 2'd1 && sel_idx == 1'b0, "R6", "relocked on primary", int'({mode, sel_idx}), 2);
        chk(hist_valid, "R9", "history valid", int'(hist_valid), 1);
        chk(hold_fcw == 16'd5001, "R10", "hold word mean", int'(hold_fcw), 5001);

        // primary loss: switch to backup (R7)
        inc[0] = 0;
        run(400);
        chk(mode == 2'd1 && sel_idx == 1'b1, "R7", "switched to backup", int'({mode, sel_idx}), 3);

        // backup drifts beyond set threshold: holdover (R4, R8)
        inc[1] = 280;
        run(1100);
        chk(oof[1] == 1'b1, "R4", "backup oof", int'(oof[1]), 1);
        chk(mode == 2'd2, "R8", "holdover with history", int'(mode), 2);
        fcw_base = 5200;
        // inside the hysteresis band: stays oof, word frozen (R5, R10)
        inc[1] = 270;
        run(1536);
        chk(oof[1] == 1'b1, "R5", "oof held in band", int'(oof[1]), 1);
        chk(mode == 2'd2, "R5", "still holdover", int'(mode), 2);
        chk(hold_fcw == 16'd5001, "R10", "hold frozen", int'(hold_fcw), 5001);
        chk(out_fcw == 16'd5001, "R13", "holdover word", int'(out_fcw), 5001);

        // back below clear threshold: relock on backup with ramp (R5, R12)
        inc[1] = 256;
        wait_mode(1, 1200);
        chk(oof[1] == 1'b0, "R5", "oof cleared", int'(oof[1]), 0);
        chk(mode == 2'd1 && sel_idx == 1'b1, "R6", "relocked on backup", int'({mode, sel_idx}), 3);
        run(1);
        chk(ramp_active, "R12", "ramp running", int'(ramp_active), 1);
        chk(out_fcw >= 16'd5001 && out_fcw < 16'd5200, "R12", "ramp not stepped", int'(out_fcw), 5004);
        run(200);
        chk(!ramp_active, "R12", "ramp done", int'(ramp_active), 0);
        chk(out_fcw == 16'd5200 || out_fcw == 16'd5202, "R12", "ramp landed", int'(out_fcw), 5200);

        // primary recovers, non-revertive then revertive (R11)
        inc[0] = 250;
        run(1536);
        chk(los[0] == 1'b0, "R3", "primary recovered", int'(los[0]), 0);
        chk(mode == 2'd1 && sel_idx == 1'b1, "R11", "stays on backup", int'({mode, sel_idx}), 3);
        revert_en = 1'b1;
        run(10);
        chk(mode == 2'd1 && sel_idx == 1'b0, "R11", "reverted to primary", int'({mode, sel_idx}), 2);

        // both lost with valid history: holdover (R8)
        run(2600);
        inc[0] = 0; inc[1] = 0;
        run(600);
        chk(hist_valid, "R9", "history kept", int'(hist_valid), 1);
        chk(mode == 2'd2, "R8", "holdover on double loss", int'(mode), 2);
        inc[0] = 250;
        run(1300);
        chk(mode == 2'd1 && sel_idx == 1'b0, "R6", "primary preferred", int'({mode, sel_idx}), 2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule